// File: doc/BRIEF.md
# I/O Window Chip-Select Decoder

This block sits on an 8-bit expansion card that lives in a 16-bit I/O address space. A static jumper vector places a 128-byte window anywhere in that space on a 128-byte boundary. An installed jumper (vector bit = 1) clears the matching base bit, and a missing jumper (vector bit = 0) sets it. Inside the window, the lowest five 16-byte slots each get their own active-low device select. The three slots above them stay unused. The four lowest address bits go through unchanged, so a device can pick one of its internal registers.

The same decode also controls the card's bidirectional 8-bit data buffer. The buffer is enabled, active low, whenever a device is selected. Its direction points toward the host only while the read strobe is low. All outputs are registered, so each one reflects the inputs sampled at the previous rising clock edge.

Top module: `iowin_cs_decoder`

## Requirements
- R1: The base is the 9-bit vector `~jumper_n_i` placed at address bits 15..7, where `jumper_n_i` bit i stands for address bit 7+i. An address whose bits 15..7 differ from the base asserts no select.
- R2: For an address in the window whose offset bits 6..4 equal n (n from 0 to 4), while at least one strobe is low, `cs_n_o[n]` is driven low one clock after the inputs are sampled.
- R3: Window offsets 50H to 7FH assert no select.
- R4: With both `rd_n_i` and `wr_n_i` high, every select stays high.
- R5: At most one bit of `cs_n_o` is low in any cycle.
- R6: `reg_sel_o` equals address bits 3..0 from one clock earlier, whatever the decode result.
- R7: `buf_en_n_o` is low exactly when some bit of `cs_n_o` is low.
- R8: `buf_dir_o` is 1 (toward the host) exactly when `rd_n_i` was low one clock earlier, and 0 otherwise.
- R9: While `rst` is high at a clock edge, the registers load their idle values: `cs_n_o` all ones, `buf_en_n_o` = 1, `buf_dir_o` = 0, `reg_sel_o` = 0.
- R10: With `jumper_n_i` = 11EH the base is 7080H. Address 7093H then lowers select 1 with register bits 3, and address 70B1H lowers select 3 with register bits 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 16 | I/O address from the host |
| jumper_n_i | input | 9 | Jumper state: 1 = installed (base bit 0) |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| cs_n_o | output | 5 | Per-slot device selects, active low |
| reg_sel_o | output | 4 | Register index within a slot |
| buf_en_n_o | output | 1 | Data buffer enable, active low |
| buf_dir_o | output | 1 | Buffer direction: 1 = to host, 0 = to card |

## Verification
The embedded properties check these every cycle:
- no two selects are ever low together;
- the buffer enable tracks the selects;
- the direction output follows the previous read strobe;
- the register bits follow the previous address;
- an idle bus, a base mismatch or an upper-slot offset leaves every select high.

Only the bench's sweeps can show the rest:
- that each select fires on exactly its own 16-address slot for a given jumper setting;
- that the inverted jumper mapping yields the expected base at both ends of the address space;
- that the worked 7080H example decodes as stated.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
  localparam int unsigned IOW_ADDR_W    = 16;
  localparam int unsigned IOW_WIN_LOG2  = 7;
  localparam int unsigned IOW_SLOT_LOG2 = 4;
  localparam int unsigned IOW_NUM_CS    = 5;

  typedef struct packed {
    logic en_n;
    logic to_host;
  } buf_ctl_t;

  localparam buf_ctl_t BUF_IDLE = '{en_n: 1'b1, to_host: 1'b0};
endpackage

// File: rtl/iowin_base_match.sv
module iowin_base_match #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned WIN_LOG2 = 7,
  localparam int unsigned JMP_W   = ADDR_W - WIN_LOG2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [JMP_W-1:0]  jumper_n_i,
  output logic              hit_o
);
  logic [JMP_W-1:0] base_hi;

  // installed jumper pulls the base bit to zero
  always_comb begin
    base_hi = ~jumper_n_i;
    hit_o   = (addr_i[ADDR_W-1:WIN_LOG2] == base_hi);
  end
endmodule

// File: rtl/iowin_slot_decode.sv
module iowin_slot_decode #(
  parameter int unsigned WIN_LOG2  = 7,
  parameter int unsigned SLOT_LOG2 = 4,
  parameter int unsigned NUM_CS    = 5,
  localparam int unsigned IDX_W    = WIN_LOG2 - SLOT_LOG2
) (
  input  logic                hit_i,
  input  logic                access_i,
  input  logic [WIN_LOG2-1:0] offset_i,
  output logic [NUM_CS-1:0]   sel_o
);
  logic [IDX_W-1:0] slot_idx;

  always_comb slot_idx = offset_i[WIN_LOG2-1:SLOT_LOG2];

  for (genvar n = 0; n < NUM_CS; n++) begin : g_slot
    always_comb sel_o[n] = hit_i && access_i && (slot_idx == IDX_W'(n));
  end
endmodule

// File: rtl/iowin_bus_ctrl.sv
module iowin_bus_ctrl
  import iowin_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     any_sel_i,
  input  logic     rd_n_i,
  output buf_ctl_t ctl_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_o <= BUF_IDLE;
    end else begin
      ctl_o.en_n    <= ~any_sel_i;
      ctl_o.to_host <= ~rd_n_i;
    end
  end

  a_r8_dir_follows_read: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ctl_o.to_host == !$past(rd_n_i)));
endmodule

// File: rtl/iowin_cs_decoder.sv
module iowin_cs_decoder
  import iowin_pkg::*;
#(
  parameter int unsigned ADDR_W    = IOW_ADDR_W,
  parameter int unsigned WIN_LOG2  = IOW_WIN_LOG2,
  parameter int unsigned SLOT_LOG2 = IOW_SLOT_LOG2,
  parameter int unsigned NUM_CS    = IOW_NUM_CS,
  localparam int unsigned JMP_W    = ADDR_W - WIN_LOG2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [JMP_W-1:0]     jumper_n_i,
  input  logic                 rd_n_i,
  input  logic                 wr_n_i,
  output logic [NUM_CS-1:0]    cs_n_o,
  output logic [SLOT_LOG2-1:0] reg_sel_o,
  output logic                 buf_en_n_o,
  output logic                 buf_dir_o
);
  localparam int unsigned IDX_W = WIN_LOG2 - SLOT_LOG2;

  logic              win_hit;
  logic              access;
  logic [NUM_CS-1:0] sel;
  buf_ctl_t          bctl;

  always_comb access = ~rd_n_i | ~wr_n_i;

  iowin_base_match #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) u_match (
    .addr_i     (addr_i),
    .jumper_n_i (jumper_n_i),
    .hit_o      (win_hit)
  );

  iowin_slot_decode #(.WIN_LOG2(WIN_LOG2), .SLOT_LOG2(SLOT_LOG2), .NUM_CS(NUM_CS)) u_slots (
    .hit_i    (win_hit),
    .access_i (access),
    .offset_i (addr_i[WIN_LOG2-1:0]),
    .sel_o    (sel)
  );

  iowin_bus_ctrl u_bus (
    .clk       (clk),
    .rst       (rst),
    .any_sel_i (|sel),
    .rd_n_i    (rd_n_i),
    .ctl_o     (bctl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n_o    <= '1;
      reg_sel_o <= '0;
    end else begin
      cs_n_o    <= ~sel;
      reg_sel_o <= addr_i[SLOT_LOG2-1:0];
    end
  end

  always_comb begin
    buf_en_n_o = bctl.en_n;
    buf_dir_o  = bctl.to_host;
  end

  a_r5_single_select: assert property (@(posedge clk) disable iff (rst)
    $countones(~cs_n_o) <= 1);

  a_r7_enable_tracks_select: assert property (@(posedge clk) disable iff (rst)
    buf_en_n_o == (&cs_n_o));

  a_r6_reg_passthrough: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (reg_sel_o == $past(addr_i[SLOT_LOG2-1:0])));

  a_r4_idle_no_select: assert property (@(posedge clk) disable iff (rst)
    (rd_n_i && wr_n_i) |=> (&cs_n_o));

  a_r1_miss_no_select: assert property (@(posedge clk) disable iff (rst)
    (addr_i[ADDR_W-1:WIN_LOG2] != ~jumper_n_i) |=> (&cs_n_o));

  a_r3_upper_slots_dead: assert property (@(posedge clk) disable iff (rst)
    (addr_i[WIN_LOG2-1:SLOT_LOG2] >= IDX_W'(NUM_CS)) |=> (&cs_n_o));
endmodule

// File: tb/tb_iowin_cs_decoder.sv
module tb_iowin_cs_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic [8:0]  jmp = '0;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [4:0]  cs_n;
  logic [3:0]  reg_sel;
  logic        buf_en_n;
  logic        buf_dir;

  int vectors = 0;
  int miscompares = 0;
  bit have_prev = 0;
  int e_cs;
  int e_reg;
  int e_en;
  int e_dir;
  string e_tag;

  always #2.5 clk = ~clk;

  iowin_cs_decoder dut (
    .clk(clk), .rst(rst), .addr_i(addr), .jumper_n_i(jmp),
    .rd_n_i(rd_n), .wr_n_i(wr_n), .cs_n_o(cs_n), .reg_sel_o(reg_sel),
    .buf_en_n_o(buf_en_n), .buf_dir_o(buf_dir)
  );

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h (addr %04h jmp %03h)", tag, act, exp, addr, jmp);
    end
  endtask

  task automatic compare_prev();
    int n_low;
    n_low = 0;
    for (int i = 0; i < 5; i++) if (!cs_n[i]) n_low++;
    check(e_tag, int'(cs_n), e_cs);
    check("R5", (n_low <= 1) ? 1 : 0, 1);
    check("R6", int'(reg_sel), e_reg);
    check("R7", int'(buf_en_n), e_en);
    check("R8", int'(buf_dir), e_dir);
  endtask

  // behavioural model: compare last vector, then apply a new one
  task automatic apply(int a, int j, int strb, string force_tag);
    int base;
    int off;
    bit inwin;
    @(negedge clk);
    if (have_prev) compare_prev();
    addr = 16'(a);
    jmp  = 9'(j);
    rd_n = !strb[0];
    wr_n = !strb[1];
    base = ((~j) & 'h1FF) * 128;
    inwin = (a >= base) && (a < base + 128);
    off = a - base;
    e_cs = 'h1F;
    if (!inwin)             e_tag = "R1";
    else if (strb == 0)     e_tag = "R4";
    else if (off >= 'h50)   e_tag = "R3";
    else begin
      e_tag = "R2";
      e_cs = 'h1F & ~(1 << (off / 16));
    end
    if (force_tag != "") e_tag = force_tag;
    e_reg = a & 'hF;
    e_en  = (e_cs == 'h1F) ? 1 : 0;
    e_dir = strb[0] ? 1 : 0;
    have_prev = 1;
  endtask

  initial begin : main
    int bases[3];
    // reset with an otherwise selecting stimulus
    addr = 16'h7080; jmp = 9'h11E; rd_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9", int'(cs_n), 'h1F);
    check("R9", int'(buf_en_n), 1);
    check("R9", int'(buf_dir), 0);
    check("R9", int'(reg_sel), 0);
    rst = 1'b0;

    // R10 worked example
    apply('h7093, 'h11E, 1, "R10");
    apply('h70B1, 'h11E, 2, "R10");
    apply('h70B1, 'h11E, 3, "R10");

    // full address sweep for the 7080H base, cycling strobe patterns
    for (int a = 0; a < 65536; a++) apply(a, 'h11E, a % 4, "");

    // base 0000H (all installed) and FF80H (none installed), plus a mid one
    bases[0] = 'h1FF; bases[1] = 'h000; bases[2] = 'h0AA;
    for (int b = 0; b < 3; b++) begin
      int lo;
      lo = ((~bases[b]) & 'h1FF) * 128 - 256;
      for (int k = 0; k < 640; k++) begin
        int a;
        a = (lo + k) & 'hFFFF;
        apply(a, bases[b], (k / 3) % 4, "");
      end
    end

    @(negedge clk);
    compare_prev();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule